// File: doc/BRIEF.md
# Unified Data Address Translation Buffer

This block translates 32-bit virtual data addresses into 29-bit physical addresses. A fully associative table, 64 entries by default, is searched in parallel. Each entry holds a virtual page number, an address space identifier, a physical page number, a page size code, a share flag, a two-bit protection field, a dirty flag and a valid flag. A lookup gives either a physical address with an ok flag, or a 12-bit fault code that the exception logic can use directly as a cause value.

Some address windows never reach the table: two unmapped kernel windows and the top control window. An access from user mode into those windows is an address error, with one 64 MiB slice at the bottom of the control window left open. With translation turned off, every address passes through as its low 29 bits. A replacement pointer steps on every table search. It is bounded by a software limit, and it picks the slot that the entry-load port writes. Results are registered: the answer to a request made in one cycle shows on the outputs after the next rising clock edge.

Top module: `utlb_xlate`

## Requirements
- R1: An entry takes part in a match only if its valid flag is set and at least one of these holds: its share flag is set, identifier checking is off, or its stored identifier equals `curAsid`. Invalid or foreign entries give a miss.
- R2: Identifier checking is off only when `singleVirt` and `reqPriv` are both 1. In every other combination it is on.
- R3: `ldSize` selects the page size: 0 = 1 KiB, 1 = 4 KiB, 2 = 64 KiB, 3 = 1 MiB. The stored page number (address bits 31:10) is compared only above the page size, so its low 0, 2, 6 or 10 bits are ignored.
- R4: If two or more entries match, the fault code is 0x140 for both reads and writes.
- R5: A translated access that matches no entry faults with 0x040 for a read and 0x060 for a write.
- R6: A user-mode access (`reqPriv`=0) to an entry whose protection bit 1 is clear faults with 0x0A0 for a read and 0x0C0 for a write. This check comes before R7 and R8.
- R7: A write to an entry whose protection bit 0 is clear faults with 0x0C0.
- R8: A write that R6 and R7 allow, to an entry whose dirty flag is clear, faults with 0x080.
- R9: On a successful translation, `rspOk`=1 and `rspFault`=0. Above the page offset, the physical address is the stored page number with the bits below the page size replaced by the virtual address bits. The offset bits come from the virtual address.
- R10: Addresses 0x80000000 to 0xBFFFFFFF and 0xE0000000 and above bypass the table whether or not translation is on. The output is the low 29 bits of the address. Address 0xC0000000 is translated.
- R11: In user mode, a bypass-window address outside 0xE0000000 to 0xE3FFFFFF is an address error: 0x0E0 for a read, 0x100 for a write.
- R12: With `mmuOn`=0, an address outside the bypass windows passes through as its low 29 bits. Bypassed and untranslated accesses leave the replacement pointer unchanged.
- R13: `replIdx` resets to 0 and steps by one on each table search. It returns to 0 when the stepped value exceeds a nonzero `cntLimit`, or when it steps past 63.
- R14: A pulse on `ldEn` writes the load fields into entry `replIdx`. `rspValid` rises in the cycle after each `reqValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | Privileged mode |
| mmuOn | input | 1 | Translation enable |
| singleVirt | input | 1 | Single virtual space mode |
| curAsid | input | 8 | Current address space identifier |
| cntLimit | input | 6 | Replacement pointer limit, 0 = none |
| ldEn | input | 1 | Load one entry |
| ldVpn | input | 22 | Virtual page number, 1 KiB units |
| ldAsid | input | 8 | Entry identifier |
| ldPpn | input | 19 | Physical page number, 1 KiB units |
| ldSize | input | 2 | Page size code |
| ldValid | input | 1 | Entry valid |
| ldShare | input | 1 | Entry shared across identifiers |
| ldProt | input | 2 | Protection: bit1 user access, bit0 write |
| ldDirty | input | 1 | Entry dirty |
| replIdx | output | 6 | Replacement pointer |
| rspValid | output | 1 | Result valid |
| rspOk | output | 1 | Translation succeeded |
| rspPaddr | output | 29 | Physical address |
| rspFault | output | 12 | Fault code, 0 when ok |

## Verification
A replacement pointer that steps at the wrong time or wraps wrongly shows at `replIdx` one edge after the search. It also shows later as loads landing on the wrong slot and overwriting live entries. A bad match mask, identifier rule or stored field shows on the next registered result, either as a wrong physical address or as a miss or multiple-hit code where a hit was expected. For that reason every page size is swept at its edges, and every protection and dirty combination is swept in both modes and both directions.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int PA_W   = 29;
  localparam int FLT_W  = 12;

  localparam logic [FLT_W-1:0] FLT_NONE     = 12'h000;
  localparam logic [FLT_W-1:0] FLT_RD_MISS  = 12'h040;
  localparam logic [FLT_W-1:0] FLT_WR_MISS  = 12'h060;
  localparam logic [FLT_W-1:0] FLT_FIRST_WR = 12'h080;
  localparam logic [FLT_W-1:0] FLT_RD_PROT  = 12'h0A0;
  localparam logic [FLT_W-1:0] FLT_WR_PROT  = 12'h0C0;
  localparam logic [FLT_W-1:0] FLT_RD_ADDR  = 12'h0E0;
  localparam logic [FLT_W-1:0] FLT_WR_ADDR  = 12'h100;
  localparam logic [FLT_W-1:0] FLT_MULTI    = 12'h140;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        pgSize;
    logic              share;
    logic [1:0]        prot;
    logic              dirty;
  } tlbEntry_t;

  typedef struct packed {
    logic loadEntry;
    logic tlbLookup;
    logic addrErr;
    logic asidCheck;
  } ctrlStrobe_t;

  // Low page-number bits that lie inside the page for a size code.
  function automatic logic [VPN_W-1:0] pageMask(input logic [1:0] sz);
    case (sz)
      2'd0:    pageMask = '0;
      2'd1:    pageMask = VPN_W'(10'h003);
      2'd2:    pageMask = VPN_W'(10'h03F);
      default: pageMask = VPN_W'(10'h3FF);
    endcase
  endfunction
endpackage

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [5:0]       regionBits,
  input  logic             reqPriv,
  input  logic             mmuOn,
  input  logic             singleVirt,
  input  logic             ldEn,
  input  logic [IDX_W-1:0] cntLimit,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] replIdx
);
  localparam logic [IDX_W:0] TOP_IDX = (IDX_W+1)'(ENTRIES - 1);

  logic inBypass;
  logic openSlice;
  logic [IDX_W:0] stepCnt;
  logic wrapNow;

  // Unmapped kernel windows (10x) and control window (111)
  assign inBypass  = (regionBits[5:4] == 2'b10) || (regionBits[5:3] == 3'b111);
  assign openSlice = (regionBits == 6'b111000);

  assign strobe.addrErr   = reqValid && inBypass && !reqPriv && !openSlice;
  assign strobe.tlbLookup = reqValid && !inBypass && mmuOn;
  assign strobe.asidCheck = !(singleVirt && reqPriv);
  assign strobe.loadEntry = ldEn;

  assign stepCnt = {1'b0, replIdx} + 1'b1;
  assign wrapNow = ((cntLimit != '0) && (stepCnt > {1'b0, cntLimit})) || (stepCnt > TOP_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replIdx <= '0;
    end else if (strobe.tlbLookup) begin
      replIdx <= wrapNow ? '0 : stepCnt[IDX_W-1:0];
    end
  end

  // R13: the last slot always wraps to zero
  p_wrap_top_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tlbLookup && replIdx == IDX_W'(ENTRIES - 1)) |=> (replIdx == '0));

  // R13: without a limit the pointer steps by exactly one
  p_step_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tlbLookup && cntLimit == '0 && replIdx != IDX_W'(ENTRIES - 1))
      |=> (replIdx == $past(replIdx) + 1'b1));

  // R12: accesses that skip the table leave the pointer alone
  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tlbLookup |=> $stable(replIdx));

  // R11: privileged accesses never raise an address error
  p_priv_no_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqPriv |-> !strobe.addrErr);
endmodule

// File: rtl/utlb_datapath.sv
module utlb_datapath
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  slot,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic [ASID_W-1:0] curAsid,
  input  tlbEntry_t         ldEntry,
  input  logic              ldValid,
  output logic              rspValid,
  output logic              rspOk,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [FLT_W-1:0]  rspFault
);
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] hitVec;
  tlbEntry_t          entryMem [ENTRIES];
  tlbEntry_t          selEntry;
  logic [VPN_W-1:0]   selMask;
  logic               anyHit;
  logic               multiHit;
  logic               nxtOk;
  logic [FLT_W-1:0]   nxtFault;
  logic [PA_W-1:0]    nxtPa;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.loadEntry) begin
      validVec[slot] <= ldValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadEntry) begin
      entryMem[slot] <= ldEntry;
    end
  end

  // Parallel compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] inPage;
    logic             asidPass;
    assign inPage   = pageMask(entryMem[g].pgSize);
    assign asidPass = entryMem[g].share || !strobe.asidCheck || (entryMem[g].asid == curAsid);
    assign hitVec[g] = validVec[g] && asidPass &&
                       (((entryMem[g].vpn ^ reqAddr[31:10]) & ~inPage) == '0);
  end

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) selEntry = tlbEntry_t'(selEntry | entryMem[i]);
    end
  end

  assign anyHit   = |hitVec;
  assign multiHit = |(hitVec & (hitVec - 1'b1));
  assign selMask  = pageMask(selEntry.pgSize);

  always_comb begin
    nxtOk    = 1'b1;
    nxtFault = FLT_NONE;
    nxtPa    = reqAddr[PA_W-1:0];
    if (strobe.addrErr) begin
      nxtOk    = 1'b0;
      nxtFault = reqWrite ? FLT_WR_ADDR : FLT_RD_ADDR;
    end else if (strobe.tlbLookup) begin
      nxtOk = 1'b0;
      if (multiHit) begin
        nxtFault = FLT_MULTI;
      end else if (!anyHit) begin
        nxtFault = reqWrite ? FLT_WR_MISS : FLT_RD_MISS;
      end else if (!reqPriv && !selEntry.prot[1]) begin
        nxtFault = reqWrite ? FLT_WR_PROT : FLT_RD_PROT;
      end else if (reqWrite && !selEntry.prot[0]) begin
        nxtFault = FLT_WR_PROT;
      end else if (reqWrite && !selEntry.dirty) begin
        nxtFault = FLT_FIRST_WR;
      end else begin
        nxtOk = 1'b1;
        nxtPa = {(selEntry.ppn & ~selMask[PPN_W-1:0]) | (reqAddr[PA_W-1:10] & selMask[PPN_W-1:0]),
                 reqAddr[9:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspFault <= FLT_NONE;
      rspPaddr <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspOk    <= nxtOk;
        rspFault <= nxtFault;
        rspPaddr <= nxtPa;
      end
    end
  end

  // R14: every request is answered on the next edge
  p_resp_next_r14: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R14: a load updates the valid flag of the addressed slot
  p_load_valid_r14: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEntry |=> (validVec[$past(slot)] == $past(ldValid)));

  // R9: a good result carries no fault code
  p_ok_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk) |-> (rspFault == FLT_NONE));

  // R4: several matching entries always report a multiple hit
  p_multi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tlbLookup && $countones(hitVec) > 1) |=> (!rspOk && rspFault == FLT_MULTI));

  // R11: an address error never translates
  p_addr_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrErr |=> !rspOk);
endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic              mmuOn,
  input  logic              singleVirt,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [IDX_W-1:0]  cntLimit,
  input  logic              ldEn,
  input  logic [VPN_W-1:0]  ldVpn,
  input  logic [ASID_W-1:0] ldAsid,
  input  logic [PPN_W-1:0]  ldPpn,
  input  logic [1:0]        ldSize,
  input  logic              ldValid,
  input  logic              ldShare,
  input  logic [1:0]        ldProt,
  input  logic              ldDirty,
  output logic [IDX_W-1:0]  replIdx,
  output logic              rspValid,
  output logic              rspOk,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [FLT_W-1:0]  rspFault
);
  ctrlStrobe_t strobe;
  tlbEntry_t   ldEntry;

  assign ldEntry = '{vpn: ldVpn, asid: ldAsid, ppn: ldPpn, pgSize: ldSize,
                     share: ldShare, prot: ldProt, dirty: ldDirty};

  utlb_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .regionBits(reqAddr[31:26]),
    .reqPriv   (reqPriv),
    .mmuOn     (mmuOn),
    .singleVirt(singleVirt),
    .ldEn      (ldEn),
    .cntLimit  (cntLimit),
    .strobe    (strobe),
    .replIdx   (replIdx)
  );

  utlb_datapath #(.ENTRIES(ENTRIES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .slot    (replIdx),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .reqPriv (reqPriv),
    .curAsid (curAsid),
    .ldEntry (ldEntry),
    .ldValid (ldValid),
    .rspValid(rspValid),
    .rspOk   (rspOk),
    .rspPaddr(rspPaddr),
    .rspFault(rspFault)
  );
endmodule

// File: tb/utlb_xlate_tb.sv
module utlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqPriv = 1'b0;
  logic        mmuOn = 1'b0;
  logic        singleVirt = 1'b0;
  logic [7:0]  curAsid = '0;
  logic [5:0]  cntLimit = '0;
  logic        ldEn = 1'b0;
  logic [21:0] ldVpn = '0;
  logic [7:0]  ldAsid = '0;
  logic [18:0] ldPpn = '0;
  logic [1:0]  ldSize = '0;
  logic        ldValid = 1'b0;
  logic        ldShare = 1'b0;
  logic [1:0]  ldProt = '0;
  logic        ldDirty = 1'b0;
  logic [5:0]  replIdx;
  logic        rspValid;
  logic        rspOk;
  logic [28:0] rspPaddr;
  logic [11:0] rspFault;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;
  int expCnt = 0;

  always #10 clk = ~clk;

  utlb_xlate dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [31:0] va, input logic [7:0] asid, input logic [31:0] pa,
                        input logic [1:0] sz, input logic v, input logic sh,
                        input logic [1:0] pr, input logic d);
    @(negedge clk);
    ldEn = 1'b1; ldVpn = va[31:10]; ldAsid = asid; ldPpn = pa[28:10];
    ldSize = sz; ldValid = v; ldShare = sh; ldProt = pr; ldDirty = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // One lookup; checks valid, ok, fault, address and the pointer model
  task automatic doLook(input string tag, input logic [31:0] va, input logic wr, input logic pv,
                        input logic expOk, input logic [31:0] expPa, input logic [11:0] expF);
    bit inBy;
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = va; reqWrite = wr; reqPriv = pv;
    inBy = (va[31:30] == 2'b10) || (va[31:29] == 3'b111);
    if (!inBy && mmuOn) begin
      n = expCnt + 1;
      if ((cntLimit != 0 && n > int'(cntLimit)) || n > 63) n = 0;
      expCnt = n;
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R14 rspValid"}, {31'b0, rspValid}, 32'd1);
    chk({tag, " ok"}, {31'b0, rspOk}, {31'b0, expOk});
    chk({tag, " fault"}, {20'b0, rspFault}, {20'b0, expF});
    if (expOk) chk({tag, " R9 paddr"}, {3'b0, rspPaddr}, expPa);
    chk({tag, " R13 replIdx"}, {26'b0, replIdx}, expCnt);
  endtask

  // Advance the pointer with a read that matches nothing
  task automatic advance();
    doLook("R5 advance miss", 32'h7FFF_FC00, 1'b0, 1'b0, 1'b0, 0, 12'h040);
  endtask

  function automatic logic [11:0] protFault(input logic [1:0] pr, input logic d,
                                            input logic pv, input logic wr);
    if (!pv && !pr[1]) return wr ? 12'h0C0 : 12'h0A0;
    if (wr && !pr[0])  return 12'h0C0;
    if (wr && !d)      return 12'h080;
    return 12'h000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset replIdx", {26'b0, replIdx}, 0);
    chk("R14 reset rspValid", {31'b0, rspValid}, 0);
    rstN = 1'b1;

    // R12: translation off
    mmuOn = 1'b0;
    doLook("R12 off read", 32'h1234_5678, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 12'h000);
    doLook("R12 off write", 32'hFFFF_0000 ^ 32'h8F00_0000, 1'b1, 1'b0, 1'b1, 32'h10FF_0000, 12'h000);
    doLook("R12 off C-region", 32'hC000_1004, 1'b1, 1'b1, 1'b1, 32'h0000_1004, 12'h000);

    mmuOn = 1'b1;
    // R5: miss codes
    doLook("R5 miss read", 32'h0040_0000, 1'b0, 1'b1, 1'b0, 0, 12'h040);
    doLook("R5 miss write", 32'h0040_0000, 1'b1, 1'b1, 1'b0, 0, 12'h060);

    // R3/R9: every page size, edges inside and outside the page
    for (int s = 0; s < 4; s++) begin
      int pgKb;
      int pgB;
      logic [31:0] va;
      logic [31:0] junk;
      pgKb = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 64 : 1024;
      pgB  = pgKb * 1024;
      va   = 32'h1000_0000 + s * 32'h0100_0000;
      junk = (pgKb - 1) << 10;
      doLoad(va | junk, 8'h00, 32'h0AB0_0000 | junk, 2'(s), 1'b1, 1'b1, 2'b11, 1'b1);
      doLook("R3 base", va, 1'b0, 1'b0, 1'b1, 32'h0AB0_0000, 12'h000);
      doLook("R3 last byte", va + pgB - 1, 1'b1, 1'b1, 1'b1, 32'h0AB0_0000 + pgB - 1, 12'h000);
      doLook("R9 middle", va + pgB / 2 + 3, 1'b0, 1'b1, 1'b1, 32'h0AB0_0000 + pgB / 2 + 3, 12'h000);
      doLook("R3 above page", va + pgB, 1'b0, 1'b1, 1'b0, 0, 12'h040);
      doLook("R3 below page", va - 1, 1'b1, 1'b1, 1'b0, 0, 12'h060);
    end

    // R1/R2: identifier rules
    doLoad(32'h2000_0000, 8'h33, 32'h0100_0000, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
    advance();
    doLoad(32'h2100_0000, 8'h55, 32'h0200_0000, 2'd1, 1'b1, 1'b1, 2'b11, 1'b1);
    advance();
    doLoad(32'h2200_0000, 8'h34, 32'h0300_0000, 2'd1, 1'b0, 1'b1, 2'b11, 1'b1);
    advance();
    curAsid = 8'h33; singleVirt = 1'b0;
    doLook("R1 own asid", 32'h2000_0010, 1'b0, 1'b0, 1'b1, 32'h0100_0010, 12'h000);
    curAsid = 8'h34;
    doLook("R1 foreign asid", 32'h2000_0010, 1'b0, 1'b0, 1'b0, 0, 12'h040);
    doLook("R1 shared entry", 32'h2100_0020, 1'b0, 1'b0, 1'b1, 32'h0200_0020, 12'h000);
    doLook("R1 invalid entry", 32'h2200_0020, 1'b0, 1'b1, 1'b0, 0, 12'h040);
    doLook("R2 priv no single", 32'h2000_0010, 1'b0, 1'b1, 1'b0, 0, 12'h040);
    singleVirt = 1'b1;
    doLook("R2 priv single", 32'h2000_0010, 1'b0, 1'b1, 1'b1, 32'h0100_0010, 12'h000);
    doLook("R2 user single", 32'h2000_0010, 1'b1, 1'b0, 1'b0, 0, 12'h060);
    singleVirt = 1'b0;

    // R6/R7/R8: protection and dirty sweep
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 2; d++) begin
        logic [31:0] va;
        va = 32'h3000_0000 + (p * 2 + d) * 32'h1000;
        doLoad(va, 8'h00, 32'h0500_0000 + (p * 2 + d) * 32'h1000, 2'd1, 1'b1, 1'b1, 2'(p), 1'(d));
        for (int pv = 0; pv < 2; pv++) begin
          for (int wr = 0; wr < 2; wr++) begin
            logic [11:0] ef;
            ef = protFault(2'(p), 1'(d), 1'(pv), 1'(wr));
            doLook("R6 R7 R8 prot sweep", va + 32'h44, 1'(wr), 1'(pv), ef == 0,
                   32'h0500_0044 + (p * 2 + d) * 32'h1000, ef);
          end
        end
      end
    end

    // R4: overlapping 1 KiB and 64 KiB entries
    doLoad(32'h4000_0000, 8'h00, 32'h0600_0000, 2'd0, 1'b1, 1'b1, 2'b11, 1'b1);
    advance();
    doLoad(32'h4000_0000, 8'h00, 32'h0700_0000, 2'd2, 1'b1, 1'b1, 2'b11, 1'b1);
    doLook("R4 multi read", 32'h4000_0100, 1'b0, 1'b1, 1'b0, 0, 12'h140);
    doLook("R4 multi write", 32'h4000_0100, 1'b1, 1'b0, 1'b0, 0, 12'h140);
    doLook("R4 single of pair", 32'h4000_8000, 1'b0, 1'b1, 1'b1, 32'h0700_8000, 12'h000);

    // R10/R11: bypass windows, both modes
    for (int m = 0; m < 2; m++) begin
      mmuOn = 1'(m);
      doLook("R10 P1 priv", 32'h8000_1234, 1'b0, 1'b1, 1'b1, 32'h0000_1234, 12'h000);
      doLook("R10 P2 priv", 32'hA0FF_FFFF, 1'b1, 1'b1, 1'b1, 32'h00FF_FFFF, 12'h000);
      doLook("R10 top of P2", 32'hBFFF_FFFF, 1'b0, 1'b1, 1'b1, 32'h1FFF_FFFF, 12'h000);
      doLook("R10 control priv", 32'hFF00_0010, 1'b1, 1'b1, 1'b1, 32'h1F00_0010, 12'h000);
      doLook("R11 open slice user", 32'hE3FF_FFFC, 1'b1, 1'b0, 1'b1, 32'h03FF_FFFC, 12'h000);
      doLook("R11 above slice read", 32'hE400_0000, 1'b0, 1'b0, 1'b0, 0, 12'h0E0);
      doLook("R11 above slice write", 32'hE400_0000, 1'b1, 1'b0, 1'b0, 0, 12'h100);
      doLook("R11 P1 user write", 32'h8000_0000, 1'b1, 1'b0, 1'b0, 0, 12'h100);
      doLook("R11 top user read", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 0, 12'h0E0);
    end
    mmuOn = 1'b1;
    doLook("R10 C-region translated", 32'hC000_0000, 1'b0, 1'b1, 1'b0, 0, 12'h040);

    // R13: full wrap without a limit, then with limits
    cntLimit = 6'd0;
    for (int k = 0; k < 70; k++) advance();
    cntLimit = 6'd5;
    for (int k = 0; k < 12; k++) advance();
    cntLimit = 6'd1;
    for (int k = 0; k < 4; k++) advance();
    cntLimit = 6'd63;
    for (int k = 0; k < 66; k++) advance();

    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule